// File: doc/BRIEF.md
# Partitionable Plus-Minus Shift Routing Network

This block is a pipelined multistage routing network for an array of N = 2^M processing lanes. Each lane presents one word per clock. The word passes through M routing stages, visited in the order M-1, M-2, ..., 0, and then reaches a final output column. A node in stage i holds the word at its own address (straight), moves it to address (j - 2^i) mod N (minus), or moves it to address (j + 2^i) mod N (plus). Each node takes its setting from a two-bit control field. The controls arrive already resolved: the block computes no routing tags and arbitrates no requests.

Partitioning splits the array into independent submachines. A submachine of 2^k lanes shares its low M-k address bits, so every shift that would change those bits must be suppressed. A per-lane partition mask and a fixed-bit count together force the nodes at the masked addresses in stages 0 up to count-1 to straight. Each submachine then keeps a complete subnetwork of its own, built from the higher stages. When two or three words meet at one node of the next column, one word survives and carries a conflict flag to the output.

Every column is registered, so a word spends M+1 clock cycles in the block. The controls and the partition inputs act on whichever words sit in a stage during the current cycle.

Top module: `adm_partnet`

## Requirements
- R1: While reset is asserted and on the first clock after it is released, every out_valid and every out_conflict bit is 0 and out_data is all zeros.
- R2: A word captured at a clock edge appears on the outputs M+1 clock edges later, and not earlier. If in_valid has been all zero for M+1 consecutive edges, out_valid is all zero.
- R3: The control code 2'b00 (straight) keeps a word at its node address in that stage. The code 2'b11 behaves exactly like 2'b00.
- R4: The control code 2'b01 (minus) at node j of stage i sends the word to node (j - 2^i) mod N of the next column.
- R5: The control code 2'b10 (plus) at node j of stage i sends the word to node (j + 2^i) mod N of the next column.
- R6: When part_mask[j] is 1 and the stage index i is less than part_fix, node j of stage i acts as straight whatever its control says. Nodes at stages i >= part_fix, and nodes whose mask bit is 0, follow their controls. A part_fix of 0 has no effect.
- R7: When several words arrive at one node, the word on the straight link wins. Without one, the word on the plus link (from j - 2^i) wins over the word on the minus link. The surviving word gets its conflict flag set, and the other words are dropped.
- R8: A lane with in_valid low injects nothing and takes no node away from a valid word. An output lane with out_valid low shows zero data and a zero conflict flag.
- R9: A conflict flag, once set on a word, stays set through the later stages until the word reaches the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | N | Per-lane word present |
| in_data | input | N*W | Per-lane word; lane j occupies bits j*W +: W |
| ctrl | input | 2*M*N | Node controls; stage i node j at bits (i*N+j)*2 +: 2 (00 straight, 01 minus, 10 plus, 11 straight) |
| part_mask | input | N | Lanes whose nodes obey the partition force |
| part_fix | input | clog2(M+1) | Number of low stages forced to straight at masked nodes |
| out_valid | output | N | Per-lane output word present |
| out_data | output | N*W | Per-lane output word, zero when invalid |
| out_conflict | output | N | Word survived at least one collision |

## Verification
A directed single word routed with plus at the top stage and minus at the bottom stage checks the arrival lane and the arrival cycle. This separates a wrong hop distance, a wrong wrap or a missing register from correct routing. Three-word, two-word and one-word meetings at one node check the priority order and show whether the conflict flag is raised only on a real collision. Streams with partition masks and all values of the fixed-bit count, including the full count, which must pass every word straight through, expose a force applied to the wrong stages or lanes. Random streams with idle lanes and mixed control codes, checked every clock against a behavioural model that scatters words from their sources, catch errors in the drop rule and in how flags are kept.

// File: rtl/adm_pkg.sv
package adm_pkg;

    typedef enum logic [1:0] {
        DIR_STRAIGHT = 2'b00,
        DIR_MINUS    = 2'b01,
        DIR_PLUS     = 2'b10,
        DIR_SPARE    = 2'b11
    } adm_dir_e;

endpackage

// File: rtl/adm_node_dir.sv
module adm_node_dir
    import adm_pkg::*;
#(
    parameter int FW    = 2,
    parameter int STAGE = 0
) (
    input  logic [1:0]    ctl,
    input  logic          mask,
    input  logic [FW-1:0] fix,
    output adm_dir_e      dir
);

    logic forced;

    always_comb begin
        forced = mask && (STAGE < int'(fix));
        dir    = DIR_STRAIGHT;
        if (!forced) begin
            unique case (ctl)
                2'b01:   dir = DIR_MINUS;
                2'b10:   dir = DIR_PLUS;
                default: dir = DIR_STRAIGHT;
            endcase
        end
    end

endmodule

// File: rtl/adm_stage.sv
module adm_stage
    import adm_pkg::*;
#(
    parameter int N     = 8,
    parameter int W     = 8,
    parameter int FW    = 2,
    parameter int STAGE = 0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N-1:0]    v_in,
    input  logic [N*W-1:0]  d_in,
    input  logic [N-1:0]    c_in,
    input  logic [2*N-1:0]  ctl,
    input  logic [N-1:0]    mask,
    input  logic [FW-1:0]   fix,
    output logic [N-1:0]    v_out,
    output logic [N*W-1:0]  d_out,
    output logic [N-1:0]    c_out
);

    localparam int HOP = 1 << STAGE;

    adm_dir_e dir [N];

    for (genvar j = 0; j < N; j++) begin : g_dec
        adm_node_dir #(.FW(FW), .STAGE(STAGE)) u_dir (
            .ctl  (ctl[j*2 +: 2]),
            .mask (mask[j]),
            .fix  (fix),
            .dir  (dir[j])
        );
    end

    for (genvar j = 0; j < N; j++) begin : g_node
        localparam int SPL = (j - HOP + N) % N;
        localparam int SMI = (j + HOP) % N;

        logic         take_st;
        logic         take_pl;
        logic         take_mi;
        logic         hit;
        logic         nxt_v;
        logic         nxt_c;
        logic [W-1:0] nxt_d;

        always_comb begin
            take_st = v_in[j]   && (dir[j]   == DIR_STRAIGHT);
            take_pl = v_in[SPL] && (dir[SPL] == DIR_PLUS);
            take_mi = v_in[SMI] && (dir[SMI] == DIR_MINUS);
            hit     = (take_st && take_pl) || (take_st && take_mi) || (take_pl && take_mi);
            nxt_v   = take_st || take_pl || take_mi;
            nxt_d   = '0;
            nxt_c   = 1'b0;
            if (take_st) begin
                nxt_d = d_in[j*W +: W];
                nxt_c = c_in[j] | hit;
            end else if (take_pl) begin
                nxt_d = d_in[SPL*W +: W];
                nxt_c = c_in[SPL] | hit;
            end else if (take_mi) begin
                nxt_d = d_in[SMI*W +: W];
                nxt_c = c_in[SMI] | hit;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                v_out[j]         <= 1'b0;
                c_out[j]         <= 1'b0;
                d_out[j*W +: W]  <= '0;
            end else begin
                v_out[j]         <= nxt_v;
                c_out[j]         <= nxt_c;
                d_out[j*W +: W]  <= nxt_d;
            end
        end
    end

endmodule

// File: rtl/adm_partnet.sv
module adm_partnet #(
    parameter  int M  = 3,
    parameter  int W  = 8,
    localparam int N  = 1 << M,
    localparam int FW = $clog2(M + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N-1:0]      in_valid,
    input  logic [N*W-1:0]    in_data,
    input  logic [2*M*N-1:0]  ctrl,
    input  logic [N-1:0]      part_mask,
    input  logic [FW-1:0]     part_fix,
    output logic [N-1:0]      out_valid,
    output logic [N*W-1:0]    out_data,
    output logic [N-1:0]      out_conflict
);

    logic [N-1:0]   col_v [M+1];
    logic [N*W-1:0] col_d [M+1];
    logic [N-1:0]   col_c [M+1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            col_v[0] <= '0;
            col_d[0] <= '0;
        end else begin
            col_v[0] <= in_valid;
            for (int j = 0; j < N; j++) begin
                col_d[0][j*W +: W] <= in_valid[j] ? in_data[j*W +: W] : '0;
            end
        end
    end

    assign col_c[0] = '0;

    for (genvar k = 1; k <= M; k++) begin : g_col
        localparam int STG = M - k;
        adm_stage #(.N(N), .W(W), .FW(FW), .STAGE(STG)) u_stage (
            .clk   (clk),
            .rst_n (rst_n),
            .v_in  (col_v[k-1]),
            .d_in  (col_d[k-1]),
            .c_in  (col_c[k-1]),
            .ctl   (ctrl[STG*N*2 +: 2*N]),
            .mask  (part_mask),
            .fix   (part_fix),
            .v_out (col_v[k]),
            .d_out (col_d[k]),
            .c_out (col_c[k])
        );
    end

    assign out_valid    = col_v[M];
    assign out_data     = col_d[M];
    assign out_conflict = col_c[M];

endmodule

// File: rtl/adm_partnet_chk.sv
module adm_partnet_chk #(
    parameter int M = 3,
    parameter int W = 8,
    parameter int N = 8
) (
    input logic           clk,
    input logic           rst_n,
    input logic [N-1:0]   in_valid,
    input logic [N-1:0]   out_valid,
    input logic [N*W-1:0] out_data,
    input logic [N-1:0]   out_conflict
);

    localparam int CW = $clog2(M + 3);

    logic [CW-1:0] idle_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idle_cnt <= '0;
        end else if (in_valid != '0) begin
            idle_cnt <= '0;
        end else if (int'(idle_cnt) <= M) begin
            idle_cnt <= idle_cnt + 1'b1;
        end
    end

    // R1: outputs are quiet on the first edge after reset release
    p_quiet_after_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (out_valid == '0 && out_conflict == '0));

    // R2: an idle input for M+1 edges drains the network
    p_drain_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(idle_cnt) > M) |-> (out_valid == '0));

    for (genvar j = 0; j < N; j++) begin : g_lane
        // R7, R8: a conflict flag only rides on a valid word
        p_flag_on_word_r7: assert property (@(posedge clk) disable iff (!rst_n)
            out_conflict[j] |-> out_valid[j]);

        // R8: an empty output lane carries zero data
        p_empty_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
            !out_valid[j] |-> (out_data[j*W +: W] == '0));
    end

endmodule

bind adm_partnet adm_partnet_chk #(.M(M), .W(W), .N(N)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .out_valid    (out_valid),
    .out_data     (out_data),
    .out_conflict (out_conflict)
);

// File: tb/adm_partnet_tb.sv
module adm_partnet_tb;

    localparam int M  = 3;
    localparam int W  = 8;
    localparam int N  = 1 << M;
    localparam int FW = $clog2(M + 1);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [N-1:0]      in_valid = '0;
    logic [N*W-1:0]    in_data = '0;
    logic [2*M*N-1:0]  ctrl = '0;
    logic [N-1:0]      part_mask = '0;
    logic [FW-1:0]     part_fix = '0;
    logic [N-1:0]      out_valid;
    logic [N*W-1:0]    out_data;
    logic [N-1:0]      out_conflict;

    int    vectors = 0;
    int    fails = 0;
    int    cyc = 0;
    string phase = "R1";

    bit mv [M+1][N];
    int md [M+1][N];
    bit mc [M+1][N];

    always #2 clk = ~clk;

    adm_partnet #(.M(M), .W(W)) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .in_valid     (in_valid),
        .in_data      (in_data),
        .ctrl         (ctrl),
        .part_mask    (part_mask),
        .part_fix     (part_fix),
        .out_valid    (out_valid),
        .out_data     (out_data),
        .out_conflict (out_conflict)
    );

    task automatic model_step();
        bit nv [M+1][N];
        int nd [M+1][N];
        bit nc [M+1][N];
        if (!rst_n) begin
            for (int k = 0; k <= M; k++)
                for (int j = 0; j < N; j++) begin
                    mv[k][j] = 0; md[k][j] = 0; mc[k][j] = 0;
                end
            return;
        end
        for (int j = 0; j < N; j++) begin
            nv[0][j] = in_valid[j];
            nd[0][j] = in_valid[j] ? int'(in_data[j*W +: W]) : 0;
            nc[0][j] = 0;
        end
        for (int k = 1; k <= M; k++) begin
            int stage = M - k;
            int h = 1 << stage;
            int cnt [N];
            int best [N];
            for (int j = 0; j < N; j++) begin
                cnt[j] = 0; best[j] = 9;
                nv[k][j] = 0; nd[k][j] = 0; nc[k][j] = 0;
            end
            for (int s = 0; s < N; s++) begin
                if (mv[k-1][s]) begin
                    int c = int'(ctrl[(stage*N + s)*2 +: 2]);
                    int step = 0;
                    int rank = 0;
                    int t;
                    bit forced = part_mask[s] && (stage < int'(part_fix));
                    if (!forced && c == 2) begin step = h;  rank = 1; end
                    if (!forced && c == 1) begin step = -h; rank = 2; end
                    t = (s + step + N) % N;
                    cnt[t]++;
                    if (rank < best[t]) begin
                        best[t] = rank;
                        nv[k][t] = 1;
                        nd[k][t] = md[k-1][s];
                        nc[k][t] = mc[k-1][s];
                    end
                end
            end
            for (int j = 0; j < N; j++)
                if (cnt[j] >= 2) nc[k][j] = 1;
        end
        mv = nv; md = nd; mc = nc;
    endtask

    task automatic compare_all();
        bit bad = 0;
        vectors++;
        for (int j = 0; j < N; j++) begin
            if (out_valid[j] !== mv[M][j] || out_data[j*W +: W] !== W'(md[M][j]) ||
                out_conflict[j] !== mc[M][j]) begin
                $display("FAIL %s lane %0d: got v=%0b d=%0h c=%0b, expected v=%0b d=%0h c=%0b",
                         phase, j, out_valid[j], out_data[j*W +: W], out_conflict[j],
                         mv[M][j], W'(md[M][j]), mc[M][j]);
                bad = 1;
            end
        end
        if (bad) fails++;
    endtask

    task automatic tick();
        model_step();
        @(posedge clk);
        @(negedge clk);
        compare_all();
    endtask

    task automatic check_lane(string tag, int lane, bit ev, int ed, bit ec);
        vectors++;
        if (out_valid[lane] !== ev || out_data[lane*W +: W] !== W'(ed) || out_conflict[lane] !== ec) begin
            fails++;
            $display("FAIL %s lane %0d: got v=%0b d=%0h c=%0b, expected v=%0b d=%0h c=%0b",
                     tag, lane, out_valid[lane], out_data[lane*W +: W], out_conflict[lane], ev, W'(ed), ec);
        end
    endtask

    task automatic set_ctl(int stage, int node, logic [1:0] val);
        ctrl[(stage*N + node)*2 +: 2] = val;
    endtask

    task automatic drain();
        in_valid = '0;
        in_data = '0;
        for (int i = 0; i <= M; i++) tick();
    endtask

    task automatic rand_inputs(bit rand_ctl, bit rand_part);
        for (int j = 0; j < N; j++) begin
            in_valid[j] = ($urandom % 4) != 0;
            in_data[j*W +: W] = W'($urandom);
        end
        if (rand_ctl) ctrl = {($urandom), ($urandom)};
        if (rand_part) begin
            part_mask = N'($urandom);
            part_fix = FW'($urandom % (M + 1));
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            fails++;
            $display("FAIL watchdog: got %0d cycles, expected under 100000", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        phase = "R1";
        @(negedge clk);
        for (int i = 0; i < 3; i++) tick();
        check_lane("R1", 0, 0, 0, 0);
        rst_n = 1'b1;
        tick();
        check_lane("R1", N-1, 0, 0, 0);

        // R3: straight everywhere, and the spare code 11 as straight
        phase = "R3";
        ctrl = '0;
        for (int i = 0; i < 20; i++) begin rand_inputs(0, 0); tick(); end
        ctrl = '1;
        for (int i = 0; i < 20; i++) begin rand_inputs(0, 0); tick(); end
        drain();

        // R2, R4, R5: lane 1, plus at stage M-1 then minus at stage 0
        phase = "R2";
        ctrl = '0;
        set_ctl(M-1, 1, 2'b10);
        set_ctl(0, (1 + (1 << (M-1))) % N, 2'b01);
        in_valid = '0; in_data = '0;
        in_valid[1] = 1'b1; in_data[1*W +: W] = 8'hA5;
        tick();
        in_valid = '0; in_data = '0;
        for (int i = 1; i < M; i++) tick();
        check_lane("R2", (1 + (1 << (M-1)) - 1) % N, 0, 0, 0);
        tick();
        check_lane("R4", (1 + (1 << (M-1)) - 1) % N, 1, 8'hA5, 0);
        check_lane("R5", 1, 0, 0, 0);
        drain();

        // R7, R9: three, two and one word meeting at stage 0 node 1
        phase = "R7";
        ctrl = '0;
        set_ctl(0, 0, 2'b10);
        set_ctl(0, 2, 2'b01);
        in_valid = '0; in_data = '0;
        in_valid[2:0] = 3'b111;
        in_data[0 +: W] = 8'h10; in_data[W +: W] = 8'h11; in_data[2*W +: W] = 8'h12;
        tick();
        in_valid[2:0] = 3'b101;
        tick();
        in_valid[2:0] = 3'b100;
        tick();
        in_valid = '0;
        for (int i = 3; i <= M; i++) tick();
        check_lane("R7", 1, 1, 8'h11, 1);
        check_lane("R8", 0, 0, 0, 0);
        tick();
        check_lane("R7", 1, 1, 8'h10, 1);
        tick();
        check_lane("R7", 1, 1, 8'h12, 0);
        drain();

        // R9: collision at top stage, then straight below keeps the flag
        phase = "R9";
        ctrl = '0;
        set_ctl(M-1, 0, 2'b10);
        in_valid = '0; in_data = '0;
        in_valid[0] = 1'b1; in_data[0 +: W] = 8'h33;
        in_valid[1 << (M-1)] = 1'b1; in_data[(1 << (M-1))*W +: W] = 8'h44;
        tick();
        in_valid = '0; in_data = '0;
        for (int i = 1; i <= M; i++) tick();
        check_lane("R9", 1 << (M-1), 1, 8'h44, 1);
        drain();

        // R6: full partition passes everything straight
        phase = "R6";
        part_mask = '1;
        part_fix = FW'(M);
        for (int i = 0; i < 20; i++) begin rand_inputs(1, 0); tick(); end
        drain();
        // R6: part_fix=2 forces stages 1 and 0 only
        ctrl = '0;
        part_fix = FW'(2);
        set_ctl(M-1, 3, 2'b10);
        set_ctl(1, (3 + (1 << (M-1))) % N, 2'b10);
        set_ctl(0, (3 + (1 << (M-1))) % N, 2'b01);
        in_valid = '0; in_data = '0;
        in_valid[3] = 1'b1; in_data[3*W +: W] = 8'h5C;
        tick();
        in_valid = '0; in_data = '0;
        for (int i = 1; i <= M; i++) tick();
        check_lane("R6", (3 + (1 << (M-1))) % N, 1, 8'h5C, 0);
        drain();
        for (int f = 0; f <= M; f++) begin
            part_fix = FW'(f);
            for (int i = 0; i < 30; i++) begin
                rand_inputs(1, 0);
                part_mask = N'($urandom);
                tick();
            end
        end
        drain();

        // R8, R9, R4, R5: random streams with idle lanes and mixed codes
        phase = "R8";
        part_mask = '0; part_fix = '0;
        for (int i = 0; i < 300; i++) begin rand_inputs(1, 0); tick(); end
        phase = "R5";
        for (int i = 0; i < 300; i++) begin rand_inputs(1, 1); tick(); end
        drain();

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule